// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block resolves one instruction operand. It takes a 6-bit operand specifier and a byte/word flag. The upper three bits select an addressing mode and the lower three bits select one of eight 16-bit general registers. Register 6 serves as the stack pointer and register 7 as the program counter. The sequencer reads the register file through a combinational read port. For some modes it also fetches an extension word from the instruction stream, or a pointer from memory, or both. Each fetch is a single-outstanding valid/ready request followed by a response strobe.

The block ends each operand with a one-cycle `op_done` pulse. That pulse carries one of two results: a register-operand flag with the register index, or the final operand address. On the same pulse it presents the register write-back that the mode implies: the stepped register for the auto modes, or the advanced program counter for the indexed modes. Executing the instruction, writing its result and handling bus faults belong to other blocks.

Word accesses must sit on even addresses. An odd word operand address, an odd pointer location or an odd program counter aborts the operand. The pulse then flags an error, no register is written and no further memory request is made.

Top module: `operand_addr_seq`

## Requirements
- R1: Mode 0 (specifier bits [5:3] = 0) completes with `op_is_reg` = 1 and `op_ea` = the register index zero-extended. It writes no register and issues no memory request.
- R2: Mode 1 completes with `op_ea` = the register contents. It writes no register and issues no memory request.
- R3: Mode 2 gives `op_ea` = the old register value and writes back the old value plus the step. Mode 4 writes back the old value minus the step and gives that new value as `op_ea`. For registers 0 to 5 the step is 1 for byte operations (`byte_op` = 1) and 2 for word operations.
- R4: Modes 2 and 4 on register 6 or register 7 step by 2 even when `byte_op` = 1.
- R5: Mode 3 reads a pointer at the old register value. Mode 5 reads a pointer at the register value minus 2. In both modes the register steps by 2 regardless of `byte_op`, and `op_ea` is the pointer read from memory.
- R6: Modes 6 and 7 read an extension word at the program counter and write back program counter + 2. For registers 0 to 6, the sum is the register value plus the extension word. Mode 6 gives that sum as `op_ea`. Mode 7 reads a pointer at the sum and gives the pointer as `op_ea`.
- R7: When the register is 7, the base for mode 6/7 is the program counter after the extension fetch (PC + 2). Mode 2 gives immediate addressing: `op_ea` = PC, PC becomes PC + 2. Mode 3 gives absolute addressing: `op_ea` = the word at PC.
- R8: Any of these conditions completes the operand with `op_err` = 1 and `upd_we` = 0, and no request is issued for an odd address:
  - a word operation whose final address is odd;
  - an odd pointer location in mode 3, 5 or 7;
  - an odd program counter in mode 6 or 7.
- R9: `mem_req_valid` stays high with a stable, even `mem_req_addr` until `mem_req_ready`. At most one request is in flight. The response is taken on the cycle `mem_rsp_valid` is high.
- R10: `op_done` is a single-cycle pulse. `upd_we` is only high with it. `start` is ignored while an operand is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving the operand on `spec` (taken only when idle) |
| spec | input | 6 | Operand specifier: [5:3] mode, [2:0] register |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 16 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 16 | Read data |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Alignment error, valid with `op_done` |
| op_is_reg | output | 1 | Operand is a register, valid with `op_done` |
| op_ea | output | 16 | Effective address, or register index for mode 0 |
| upd_we | output | 1 | Register write-back enable |
| upd_idx | output | 3 | Register write-back index |
| upd_val | output | 16 | Register write-back value |

## Verification
The hardest path to reach is mode 7 through a general register. It needs two dependent memory round trips and has three separate points where an odd address can abort it. The stimulus sets up these cases:
- memory images that make the indexed sum odd, so the first fetch completes and the second must never appear;
- a pointer that is odd only for word operations;
- a program counter that is odd before any fetch.

These runs use randomly stalled `mem_req_ready` and response latencies of zero to three cycles. Stray `start` pulses are injected in the middle of the long sequence to show that they are ignored.

// File: rtl/oas_pkg.sv
// Shared types and constants for the operand addressing mode sequencer.
// Assumes a 3-bit mode field; mode numbering is architectural and fixed.
package oas_pkg;

    localparam logic [2:0] M_REG   = 3'd0;
    localparam logic [2:0] M_DEF   = 3'd1;
    localparam logic [2:0] M_AINC  = 3'd2;
    localparam logic [2:0] M_AINCD = 3'd3;
    localparam logic [2:0] M_ADEC  = 3'd4;
    localparam logic [2:0] M_ADECD = 3'd5;
    localparam logic [2:0] M_IDX   = 3'd6;
    localparam logic [2:0] M_IDXD  = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PCRD,
        S_EXTREQ,
        S_EXTWAIT,
        S_PTRREQ,
        S_PTRWAIT,
        S_DONE
    } oas_state_e;

endpackage

// File: rtl/oas_step.sv
// Auto-increment / auto-decrement address and write-back value generator.
// Assumes mode is one of 2..5 when its outputs are used; bit 0 of the mode
// marks the deferred forms, which always step by the word size.
module oas_step #(
    parameter int DW         = 16,
    parameter int RW         = 3,
    parameter int SP_IDX     = 6,
    parameter int WORD_BYTES = 2
) (
    input  logic [2:0]    mode,
    input  logic [RW-1:0] ridx,
    input  logic          byte_op,
    input  logic [DW-1:0] rval,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] nval
);
    localparam logic [DW-1:0] STEP_B = DW'(1);
    localparam logic [DW-1:0] STEP_W = DW'(WORD_BYTES);

    logic [DW-1:0] step;

    // Choose the step size: byte only for non-deferred modes on ordinary registers.
    always_comb begin
        if (byte_op && !mode[0] && (int'(ridx) < SP_IDX)) step = STEP_B;
        else                                                step = STEP_W;
    end

    // Post-increment uses the old value; pre-decrement uses the new one.
    always_comb begin
        if (mode[2]) begin
            nval = rval - step;
            addr = nval;
        end else begin
            nval = rval + step;
            addr = rval;
        end
    end
endmodule

// File: rtl/oas_index.sv
// Indexed address adder. Picks the base register value, or the program
// counter already advanced past the extension word when the register is
// the program counter, and adds the extension word.
module oas_index #(
    parameter int DW         = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic          base_is_pc,
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] rval,
    input  logic [DW-1:0] ext,
    output logic [DW-1:0] sum
);
    logic [DW-1:0] base;

    // Select the base and form the indexed sum.
    always_comb begin
        base = base_is_pc ? (pc + DW'(WORD_BYTES)) : rval;
        sum  = base + ext;
    end
endmodule

// File: rtl/oas_align.sv
// Word alignment test on the low address bits. Assumes the word size is a
// power of two and takes only the bits below it.
module oas_align #(
    parameter int AB = 1
) (
    input  logic [AB-1:0] lsb,
    output logic          odd
);
    // Any set bit below the word boundary is a misalignment.
    always_comb odd = |lsb;
endmodule

// File: rtl/operand_addr_seq.sv
// Operand addressing mode sequencer. Resolves one operand specifier into a
// register operand or a final operand address, issues extension-word and
// pointer reads (one outstanding, valid/ready request, strobed response),
// and reports the register write-back for the mode on a one-cycle done
// pulse. Assumes the register file read is combinational and that the
// register file is not modified by others while an operand is in progress.
module operand_addr_seq #(
    parameter int DW         = 16,
    parameter int RW         = 3,
    parameter int SP_IDX     = 6,
    parameter int PC_IDX     = 7,
    parameter int WORD_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW+2:0] spec,
    input  logic          byte_op,
    output logic [RW-1:0] rf_raddr,
    input  logic [DW-1:0] rf_rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [DW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          op_done,
    output logic          op_err,
    output logic          op_is_reg,
    output logic [DW-1:0] op_ea,
    output logic          upd_we,
    output logic [RW-1:0] upd_idx,
    output logic [DW-1:0] upd_val
);
    import oas_pkg::*;

    localparam int AB       = $clog2(WORD_BYTES);
    localparam int NCHK     = 4;
    localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

    oas_state_e    state;
    logic [2:0]    mode_q;
    logic [RW-1:0] reg_q;
    logic          byte_q;
    logic [DW-1:0] rval_q;
    logic [DW-1:0] pc_q;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] ea_q;
    logic          isreg_q;
    logic          err_q;
    logic          we_q;
    logic [RW-1:0] widx_q;
    logic [DW-1:0] wval_q;

    logic [2:0]    s_mode;
    logic [RW-1:0] s_reg;
    logic [DW-1:0] step_addr;
    logic [DW-1:0] step_nval;
    logic [DW-1:0] idx_sum;
    logic [DW-1:0] idle_addr;
    logic [DW-1:0] chk_addr [NCHK];
    logic [NCHK-1:0] odd;

    assign s_mode = spec[RW+2:RW];
    assign s_reg  = spec[RW-1:0];

    oas_step #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX), .WORD_BYTES(WORD_BYTES)) u_step (
        .mode    (s_mode),
        .ridx    (s_reg),
        .byte_op (byte_op),
        .rval    (rf_rdata),
        .addr    (step_addr),
        .nval    (step_nval)
    );

    oas_index #(.DW(DW), .WORD_BYTES(WORD_BYTES)) u_index (
        .base_is_pc (reg_q == PC_R),
        .pc         (pc_q),
        .rval       (rval_q),
        .ext        (mem_rsp_data),
        .sum        (idx_sum)
    );

    // Address examined at start: plain register for mode 1, stepped otherwise.
    always_comb idle_addr = (s_mode == M_DEF) ? rf_rdata : step_addr;

    // Gather the four alignment check points.
    always_comb begin
        chk_addr[0] = idle_addr;
        chk_addr[1] = rf_rdata;
        chk_addr[2] = idx_sum;
        chk_addr[3] = mem_rsp_data;
    end

    generate
        for (genvar g = 0; g < NCHK; g++) begin : g_align
            oas_align #(.AB(AB)) u_align (
                .lsb (chk_addr[g][AB-1:0]),
                .odd (odd[g])
            );
        end
    endgenerate

    // Register file read port: program counter while fetching it, else the specifier's register.
    always_comb rf_raddr = (state == S_PCRD) ? PC_R : s_reg;

    // Memory request port: extension fetch at the PC, or pointer fetch.
    always_comb begin
        mem_req_valid = (state == S_EXTREQ) || (state == S_PTRREQ);
        mem_req_addr  = (state == S_EXTREQ) ? pc_q : ptr_q;
    end

    // Completion outputs, qualified by the done state.
    always_comb begin
        op_done   = (state == S_DONE);
        op_err    = op_done && err_q;
        op_is_reg = op_done && isreg_q;
        op_ea     = ea_q;
        upd_we    = op_done && we_q;
        upd_idx   = widx_q;
        upd_val   = wval_q;
    end

    // Sequencer: walks the fetch steps the mode needs and records the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            mode_q  <= M_REG;
            reg_q   <= '0;
            byte_q  <= 1'b0;
            rval_q  <= '0;
            pc_q    <= '0;
            ptr_q   <= '0;
            ea_q    <= '0;
            isreg_q <= 1'b0;
            err_q   <= 1'b0;
            we_q    <= 1'b0;
            widx_q  <= '0;
            wval_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q  <= s_mode;
                        reg_q   <= s_reg;
                        byte_q  <= byte_op;
                        rval_q  <= rf_rdata;
                        isreg_q <= 1'b0;
                        err_q   <= 1'b0;
                        we_q    <= 1'b0;
                        widx_q  <= s_reg;
                        wval_q  <= step_nval;
                        unique case (s_mode)
                            M_REG: begin
                                isreg_q <= 1'b1;
                                ea_q    <= {{(DW-RW){1'b0}}, s_reg};
                                state   <= S_DONE;
                            end
                            M_DEF: begin
                                ea_q  <= rf_rdata;
                                err_q <= !byte_op && odd[0];
                                state <= S_DONE;
                            end
                            M_AINC, M_ADEC: begin
                                ea_q  <= step_addr;
                                err_q <= !byte_op && odd[0];
                                we_q  <= !(!byte_op && odd[0]);
                                state <= S_DONE;
                            end
                            M_AINCD, M_ADECD: begin
                                ptr_q <= step_addr;
                                if (odd[0]) begin
                                    err_q <= 1'b1;
                                    state <= S_DONE;
                                end else begin
                                    we_q  <= 1'b1;
                                    state <= S_PTRREQ;
                                end
                            end
                            default: begin
                                state <= S_PCRD;
                            end
                        endcase
                    end
                end
                S_PCRD: begin
                    pc_q   <= rf_rdata;
                    widx_q <= PC_R;
                    wval_q <= rf_rdata + DW'(WORD_BYTES);
                    if (odd[1]) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        we_q  <= 1'b1;
                        state <= S_EXTREQ;
                    end
                end
                S_EXTREQ: begin
                    if (mem_req_ready) state <= S_EXTWAIT;
                end
                S_EXTWAIT: begin
                    if (mem_rsp_valid) begin
                        if (mode_q == M_IDX) begin
                            ea_q <= idx_sum;
                            if (!byte_q && odd[2]) begin
                                err_q <= 1'b1;
                                we_q  <= 1'b0;
                            end
                            state <= S_DONE;
                        end else begin
                            ptr_q <= idx_sum;
                            if (odd[2]) begin
                                err_q <= 1'b1;
                                we_q  <= 1'b0;
                                state <= S_DONE;
                            end else begin
                                state <= S_PTRREQ;
                            end
                        end
                    end
                end
                S_PTRREQ: begin
                    if (mem_req_ready) state <= S_PTRWAIT;
                end
                S_PTRWAIT: begin
                    if (mem_rsp_valid) begin
                        ea_q <= mem_rsp_data;
                        if (!byte_q && odd[3]) begin
                            err_q <= 1'b1;
                            we_q  <= 1'b0;
                        end
                        state <= S_DONE;
                    end
                end
                S_DONE: begin
                    state <= S_IDLE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/operand_addr_seq_chk.sv
// Protocol checker for the operand addressing mode sequencer, bound to the
// top module. Observes ports only.
module operand_addr_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [DW-1:0] mem_req_addr,
    input logic          op_done,
    input logic          op_err,
    input logic          op_is_reg,
    input logic          upd_we
);
    // A stalled request keeps its valid and its address.
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // No request ever goes out on an odd address.
    assert_req_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !mem_req_addr[0]);

    // An aborted operand writes nothing back.
    assert_err_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_done && !upd_we);

    // A register operand has no write-back and no error.
    assert_reg_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && op_is_reg |-> !upd_we && !op_err);

    // Done lasts one cycle only.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // Write-back only accompanies done.
    assert_we_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> op_done);

    // No request is left open when the operand completes.
    assert_no_req_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !mem_req_valid);
endmodule

bind operand_addr_seq operand_addr_seq_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .op_done       (op_done),
    .op_err        (op_err),
    .op_is_reg     (op_is_reg),
    .upd_we        (upd_we)
);

// File: tb/operand_addr_seq_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference (register array, sparse memory, request
// queues) compared against the sequencer on every clock and per operand.
module operand_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  spec = '0;
    logic        byte_op = 1'b0;
    logic [2:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;
    logic        op_done, op_err, op_is_reg, upd_we;
    logic [15:0] op_ea, upd_val;
    logic [2:0]  upd_idx;

    int checks = 0;
    int errors = 0;

    logic [15:0] regs [8];
    logic [15:0] mem_img [logic [15:0]];
    logic [15:0] got_req [$];
    logic [15:0] exp_req [$];
    logic [15:0] exp_regs [8];
    logic [15:0] exp_ea;
    logic        exp_err, exp_isreg;
    int          done_cnt = 0;
    int          lat = 0;
    bit          stall_en = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          pend = 0;
    int          pend_wait = 0;
    logic [15:0] pend_data = '0;
    logic [15:0] hold_addr = '0;
    bit          hold_chk = 0;

    always #4 clk = ~clk;

    operand_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .op_done(op_done), .op_err(op_err),
        .op_is_reg(op_is_reg), .op_ea(op_ea), .upd_we(upd_we),
        .upd_idx(upd_idx), .upd_val(upd_val)
    );

    assign rf_rdata = regs[rf_raddr];

    // Register file write port.
    always @(posedge clk) if (upd_we) regs[upd_idx] <= upd_val;

    function automatic logic [15:0] memrd(input logic [15:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return {a[7:0], a[15:8]} & 16'hFFFE;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory side: ready stalls, latency, request logging, R9 hold check each clock.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (hold_chk) begin
            check(mem_req_valid && mem_req_addr == hold_addr, "R9 request held while stalled",
                  mem_req_addr, hold_addr);
        end
        hold_chk = 0;
        if (pend) begin
            if (pend_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pend_data;
                pend = 0;
            end else begin
                pend_wait--;
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready = stall_en ? lfsr[0] : 1'b1;
        if (mem_req_valid && rst_n) begin
            if (mem_req_ready) begin
                if (pend) check(0, "R9 second request in flight", mem_req_addr, 16'h0);
                pend = 1;
                pend_wait = lat;
                pend_data = memrd(mem_req_addr);
                got_req.push_back(mem_req_addr);
            end else begin
                hold_chk = 1;
                hold_addr = mem_req_addr;
            end
        end
        if (op_done) done_cnt++;
    end

    // Reference model: expected result, requests and registers for one operand.
    task automatic model(input logic [5:0] sp, input bit bop);
        int m = int'(sp[5:3]);
        int r = int'(sp[2:0]);
        logic [15:0] rv = regs[r];
        logic [15:0] pc = regs[7];
        logic [15:0] st, p, a, x;
        bit we = 0;
        int widx = 0;
        logic [15:0] wval = 0;
        exp_req.delete();
        exp_isreg = 0; exp_err = 0; exp_ea = 0;
        st = (m == 3 || m == 5 || !bop || r >= 6) ? 16'd2 : 16'd1;
        case (m)
            0: begin exp_isreg = 1; exp_ea = 16'(r); end
            1: begin exp_ea = rv; exp_err = !bop && rv[0]; end
            2, 4: begin
                a = (m == 2) ? rv : rv - st;
                exp_ea = a; widx = r; wval = (m == 2) ? rv + st : rv - st;
                exp_err = !bop && a[0]; we = !exp_err;
            end
            3, 5: begin
                p = (m == 3) ? rv : rv - 16'd2;
                widx = r; wval = (m == 3) ? rv + 16'd2 : rv - 16'd2;
                if (p[0]) exp_err = 1;
                else begin
                    exp_req.push_back(p);
                    exp_ea = memrd(p);
                    exp_err = !bop && exp_ea[0];
                end
                we = !exp_err;
            end
            default: begin
                widx = 7; wval = pc + 16'd2;
                if (pc[0]) exp_err = 1;
                else begin
                    exp_req.push_back(pc);
                    x = memrd(pc);
                    a = ((r == 7) ? pc + 16'd2 : rv) + x;
                    if (m == 6) begin
                        exp_ea = a; exp_err = !bop && a[0];
                    end else if (a[0]) exp_err = 1;
                    else begin
                        exp_req.push_back(a);
                        exp_ea = memrd(a);
                        exp_err = !bop && exp_ea[0];
                    end
                end
                we = !exp_err;
            end
        endcase
        for (int i = 0; i < 8; i++) exp_regs[i] = regs[i];
        if (we) exp_regs[widx] = wval;
    endtask

    // Run one operand and compare everything observable at the ports.
    task automatic run_op(input logic [5:0] sp, input bit bop, input string tag, input bit poke);
        int n = 0;
        bit seen = 0;
        logic cerr, creg;
        logic [15:0] cea;
        model(sp, bop);
        got_req.delete();
        @(negedge clk);
        done_cnt = 0;
        spec = sp; byte_op = bop; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < 500) begin
            if (op_done) begin
                seen = 1; cerr = op_err; creg = op_is_reg; cea = op_ea;
                break;
            end
            if (poke && n == 1) begin start = 1'b1; spec = 6'o00; end
            if (poke && n == 2) begin start = 1'b0; spec = sp; end
            @(negedge clk);
            n++;
        end
        if (!seen) begin
            check(0, {tag, " watchdog: no done"}, 16'h0, 16'h1);
            return;
        end
        repeat (4) @(negedge clk);
        check(done_cnt == 1, {tag, " R10 one done pulse"}, 16'(done_cnt), 16'd1);
        check(cerr == exp_err, {tag, " R8 error flag"}, 16'(cerr), 16'(exp_err));
        check(creg == exp_isreg, {tag, " R1 register flag"}, 16'(creg), 16'(exp_isreg));
        if (!exp_err) check(cea == exp_ea, {tag, " effective address"}, cea, exp_ea);
        check(got_req.size() == exp_req.size(), {tag, " R9 request count"},
              16'(got_req.size()), 16'(exp_req.size()));
        for (int i = 0; i < exp_req.size() && i < got_req.size(); i++)
            check(got_req[i] == exp_req[i], {tag, " request address"}, got_req[i], exp_req[i]);
        for (int i = 0; i < 8; i++)
            check(regs[i] == exp_regs[i], {tag, " register write-back"}, regs[i], exp_regs[i]);
    endtask

    task automatic setr(input int i, input logic [15:0] v);
        regs[i] = v;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'(16'h0100 * i);
        regs[7] = 16'h0400;
        repeat (3) @(negedge clk);
        check(!op_done && !mem_req_valid && !upd_we, "reset state idle", {13'b0, op_done, mem_req_valid, upd_we}, 16'h0);
        rst_n = 1'b1;

        for (int pass = 0; pass < 2; pass++) begin
            stall_en = (pass == 1);
            lat = pass * 2;
            regs[7] = 16'h0400 + 16'(pass * 16'h40);
            run_op(6'o03, 0, "R1 mode0", 0);
            setr(2, 16'h1234); run_op(6'o12, 0, "R2 mode1 word", 0);
            setr(2, 16'h1235); run_op(6'o12, 1, "R2 mode1 byte odd", 0);
            setr(1, 16'h2001); run_op(6'o21, 1, "R3 inc byte", 0);
            setr(1, 16'h2002); run_op(6'o21, 0, "R3 inc word", 0);
            setr(0, 16'h3000); run_op(6'o40, 1, "R3 dec byte", 0);
            setr(6, 16'h0800); run_op(6'o46, 1, "R4 sp dec byte", 0);
            run_op(6'o26, 1, "R4 sp inc byte", 0);
            run_op(6'o27, 1, "R4 R7 immediate byte", 0);
            mem_img[16'h1000] = 16'h4445;
            setr(2, 16'h1000); run_op(6'o32, 1, "R5 inc deferred byte", 0);
            mem_img[16'h1006] = 16'h5554;
            setr(4, 16'h1008); run_op(6'o54, 0, "R5 dec deferred word", 0);
            mem_img[regs[7]] = 16'h0020;
            setr(5, 16'h0100); run_op(6'o65, 0, "R6 indexed", 0);
            mem_img[regs[7]] = 16'h0010;
            mem_img[16'h0210] = 16'h6666;
            setr(1, 16'h0200); run_op(6'o71, 0, "R6 index deferred", 0);
            mem_img[regs[7]] = 16'h0100;
            run_op(6'o67, 0, "R7 relative", 0);
            mem_img[regs[7]] = 16'h0010;
            mem_img[regs[7] + 16'h0012] = 16'h7770;
            run_op(6'o77, 0, "R7 relative deferred", 0);
            mem_img[regs[7]] = 16'h9000;
            run_op(6'o37, 0, "R7 absolute", 0);
            setr(2, 16'h1235); run_op(6'o12, 0, "R8 mode1 odd word", 0);
            setr(3, 16'h0011); run_op(6'o23, 0, "R8 inc odd word", 0);
            setr(2, 16'h1001); run_op(6'o32, 1, "R8 odd pointer location", 0);
            mem_img[16'h1100] = 16'h3333;
            setr(2, 16'h1100); run_op(6'o32, 0, "R8 odd pointer word", 0);
            setr(2, 16'h1100); run_op(6'o32, 1, "R8 odd pointer byte ok", 0);
            mem_img[regs[7]] = 16'h0000;
            setr(1, 16'h0201); run_op(6'o71, 0, "R8 odd indexed sum", 0);
            mem_img[regs[7]] = 16'h0001;
            setr(5, 16'h0100); run_op(6'o65, 1, "R6 indexed byte odd ok", 0);
            setr(7, 16'h0401); run_op(6'o65, 0, "R8 odd pc", 0);
            setr(7, 16'h0500 + 16'(pass * 16'h40));
            mem_img[regs[7]] = 16'h0010;
            setr(1, 16'h0200); run_op(6'o71, 0, "R10 start ignored while busy", 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog for the whole run.
    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule